// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status Flags

This block is the receive half of an asynchronous serial port. It watches a serial line with a 16x oversampling tick, confirms a start bit at its middle, then samples each data bit, an optional parity bit and the first stop bit at mid-bit. Each finished character goes into a two-entry buffer. The buffer is read through a valid/ready pair. Sticky flags report a bad stop bit, a parity mismatch and a character that arrived while the buffer was full.

Each confirmed start bit produces a one-cycle start pulse. A gated event output, `wake`, forwards start and completion events to power control. The gating uses a detection enable and two event selects. Removing the receive enable resets the receiver, empties the buffer and clears every flag.

Top module: `serial_rx`

## Requirements
- R1: After reset, `rd_valid`, `start_pulse`, `wake` and all three error flags are 0.
- R2: A low level is taken as a start bit only if the line is still low at the eighth tick after it was first seen. A low pulse shorter than that produces no start pulse and no character.
- R3: `char_size` selects the data bits per character: 0 gives 8, 1 gives 9, 5 gives 5, 6 gives 6, 7 gives 7, and the unused codes 2 to 4 give 8. Bits arrive LSB first, fill `rd_data` from bit 0 upward, and unused upper bits read 0.
- R4: With `par_en` high, one parity bit follows the data. `par_odd` = 0 means even and 1 means odd. `err_parity` is set when the XOR of the data bits and the parity bit differs from `par_odd`. With `par_en` low, no parity bit is expected and `err_parity` is never set.
- R5: `err_frame` is set when the first stop bit is sampled low. The character is still stored.
- R6: The buffer holds two characters and delivers them in arrival order. A character is removed when `rd_valid` and `rd_ready` are both high. The head stays stable while it waits.
- R7: A character that completes while two characters are held is discarded and sets `err_overrun`. The held characters are unchanged.
- R8: While `rx_en` is low, the receiver stays idle, the buffer is empty and all three flags are 0, from the cycle after `rx_en` is sampled low.
- R9: A high `clr_status` clears all three flags. If a flag's setting event falls in the same cycle, the flag is set.
- R10: Each accepted start bit gives exactly one single-cycle `start_pulse`.
- R11: `wake` pulses for an accepted start when `sof_en` and `ie_start` are high, and for a completed character when `sof_en` and `ie_done` are high. With `sof_en` low, or with both selects low, `wake` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low flushes buffer and flags |
| os_tick | input | 1 | 16x oversampling tick |
| rxd | input | 1 | Serial input line, idle high |
| char_size | input | 3 | Character size code (R3) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 0 even, 1 odd parity |
| sof_en | input | 1 | Start-of-frame event enable |
| ie_start | input | 1 | Forward start events to `wake` |
| ie_done | input | 1 | Forward completion events to `wake` |
| clr_status | input | 1 | Single-cycle clear of the three flags |
| rd_data | output | 9 | Head character of the buffer |
| rd_valid | output | 1 | Buffer holds at least one character |
| rd_ready | input | 1 | Consumer takes the head character |
| err_frame | output | 1 | Stop bit was sampled low |
| err_parity | output | 1 | Parity mismatch seen |
| err_overrun | output | 1 | Character lost to a full buffer |
| start_pulse | output | 1 | One cycle per accepted start bit |
| wake | output | 1 | Gated start/completion event |

## Verification
A flag-setting completion can land in the same cycle as a `clr_status` pulse. The bench provokes this by raising `clr_status` on the cycle computed from the frame start, namely the cycle in which the registered completion of a low-stop frame reaches the flags. It then requires `err_frame` to read 1. A later `clr_status` alone must bring it back to 0, which shows the clear works and that the earlier result came from set priority.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int DATA_W = 9;
    localparam int OVS    = 16;
    localparam int NB_W   = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_char_t;

    // Non-linear size code: unused codes fall back to eight bits
    function automatic logic [NB_W-1:0] char_bits(input logic [2:0] code);
        case (code)
            3'd1:    char_bits = NB_W'(9);
            3'd5:    char_bits = NB_W'(5);
            3'd6:    char_bits = NB_W'(6);
            3'd7:    char_bits = NB_W'(7);
            default: char_bits = NB_W'(8);
        endcase
    endfunction

    // High when the data bits plus parity bit disagree with the selected mode
    function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                        input logic pbit,
                                        input logic odd);
        parity_bad = (^d) ^ pbit ^ odd;
    endfunction

endpackage

// File: rtl/rx_sampler.sv
module rx_sampler
    import serial_rx_pkg::*;
#(
    parameter int OVS_N = OVS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic       rxd,
    input  logic [2:0] size_code,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       start_pulse,
    output logic       done,
    output rx_char_t   char_o
);

    localparam int CNT_W = $clog2(OVS_N);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS_N / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS_N - 1);

    rx_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [NB_W-1:0]    idx;
    logic [DATA_W-1:0]  shreg;
    logic               pbit;
    logic [NB_W-1:0]    nbits;
    logic               at_sample;

    assign nbits     = char_bits(size_code);
    assign at_sample = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state       <= RX_IDLE;
            cnt         <= '0;
            idx         <= '0;
            shreg       <= '0;
            pbit        <= 1'b0;
            start_pulse <= 1'b0;
            done        <= 1'b0;
            char_o      <= '0;
        end else begin
            start_pulse <= 1'b0;
            done        <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        cnt <= '0;
                        if (!rxd) state <= RX_START;
                    end
                    RX_START: begin
                        if (cnt == MID) begin
                            cnt <= '0;
                            if (!rxd) begin
                                state       <= RX_DATA;
                                start_pulse <= 1'b1;
                                shreg       <= '0;
                                idx         <= '0;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (at_sample) begin
                            cnt        <= '0;
                            shreg[idx] <= rxd;
                            idx        <= idx + 1'b1;
                            if (idx == nbits - 1'b1)
                                state <= par_en ? RX_PAR : RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (at_sample) begin
                            cnt   <= '0;
                            pbit  <= rxd;
                            state <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (at_sample) begin
                            cnt         <= '0;
                            done        <= 1'b1;
                            char_o.data <= shreg;
                            char_o.perr <= par_en && parity_bad(shreg, pbit, par_odd);
                            char_o.ferr <= !rxd;
                            state       <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/rx_buf.sv
module rx_buf #(
    parameter int W     = 9,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         valid,
    output logic         full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign valid   = (count != '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (do_push && !flush && wp == PTR_W'(i))
                mem[i] <= wdata;
        end
    end

endmodule

// File: rtl/rx_status.sv
module rx_status #(
    parameter int NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clr,
    input  logic [NFLAG-1:0] set,
    output logic [NFLAG-1:0] flags
);

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || !en)
                flags[i] <= 1'b0;
            else if (set[i])
                flags[i] <= 1'b1;
            else if (clr)
                flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_rx_pkg::*;
#(
    parameter int BUF_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic [2:0]        char_size,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              sof_en,
    input  logic              ie_start,
    input  logic              ie_done,
    input  logic              clr_status,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              start_pulse,
    output logic              wake
);

    rx_char_t   ch;
    logic       done;
    logic       buf_full;
    logic [2:0] flag_set, flag_q;

    rx_sampler #(.OVS_N(OVS)) u_samp (
        .clk        (clk),
        .rst        (rst),
        .en         (rx_en),
        .tick       (os_tick),
        .rxd        (rxd),
        .size_code  (char_size),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .start_pulse(start_pulse),
        .done       (done),
        .char_o     (ch)
    );

    rx_buf #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk  (clk),
        .rst  (rst),
        .flush(!rx_en),
        .push (done),
        .wdata(ch.data),
        .pop  (rd_ready),
        .rdata(rd_data),
        .valid(rd_valid),
        .full (buf_full)
    );

    assign flag_set = {done && buf_full, done && ch.perr, done && ch.ferr};

    rx_status #(.NFLAG(3)) u_stat (
        .clk  (clk),
        .rst  (rst),
        .en   (rx_en),
        .clr  (clr_status),
        .set  (flag_set),
        .flags(flag_q)
    );

    assign err_frame   = flag_q[0];
    assign err_parity  = flag_q[1];
    assign err_overrun = flag_q[2];

    assign wake = sof_en && ((ie_start && start_pulse) || (ie_done && done));

endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_en,
    input logic       sof_en,
    input logic       ie_start,
    input logic       ie_done,
    input logic [8:0] rd_data,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic       err_frame,
    input logic       err_parity,
    input logic       err_overrun,
    input logic       start_pulse,
    input logic       wake
);

    p_off_clears_r8: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!rd_valid && !err_frame && !err_parity && !err_overrun));

    p_off_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !start_pulse);

    p_start_single_r10: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    p_wake_gate_r11: assert property (@(posedge clk) disable iff (rst)
        wake |-> (sof_en && (ie_start || ie_done)));

    p_ovf_when_full_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overrun) |-> rd_valid);

    p_head_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_en && rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

bind serial_rx serial_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (rx_en),
    .sof_en     (sof_en),
    .ie_start   (ie_start),
    .ie_done    (ie_done),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .err_frame  (err_frame),
    .err_parity (err_parity),
    .err_overrun(err_overrun),
    .start_pulse(start_pulse),
    .wake       (wake)
);

// File: tb/tb_serial_rx.sv
module tb_serial_rx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0;
    logic       os_tick = 1'b1;
    logic       rxd = 1'b1;
    logic [2:0] char_size = 3'd0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       sof_en = 1'b0;
    logic       ie_start = 1'b0;
    logic       ie_done = 1'b0;
    logic       clr_status = 1'b0;
    logic       rd_ready = 1'b0;
    logic [8:0] rd_data;
    logic       rd_valid, err_frame, err_parity, err_overrun, start_pulse, wake;

    int n_chk  = 0;
    int n_fail = 0;
    int n_start = 0;
    int n_wake  = 0;

    always #4 clk = ~clk;

    serial_rx dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .os_tick(os_tick), .rxd(rxd),
        .char_size(char_size), .par_en(par_en), .par_odd(par_odd),
        .sof_en(sof_en), .ie_start(ie_start), .ie_done(ie_done),
        .clr_status(clr_status), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .err_frame(err_frame), .err_parity(err_parity),
        .err_overrun(err_overrun), .start_pulse(start_pulse), .wake(wake)
    );

    always @(negedge clk) begin
        if (start_pulse) n_start++;
        if (wake) n_wake++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    function automatic int size_of(input logic [2:0] c);
        case (c)
            3'd1: return 9;
            3'd5: return 5;
            3'd6: return 6;
            3'd7: return 7;
            default: return 8;
        endcase
    endfunction

    // One frame: start, data LSB first, optional parity, stop, then one idle bit
    task automatic send(input logic [8:0] d, input logic [2:0] sz, input logic pen,
                        input logic podd, input logic pflip, input logic stopb);
        int nb;
        logic p;
        nb = size_of(sz);
        p  = podd;
        for (int i = 0; i < nb; i++) p ^= d[i];
        p ^= pflip;
        @(negedge clk); rxd = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            repeat (16) @(negedge clk);
        end
        if (pen) begin
            rxd = p;
            repeat (16) @(negedge clk);
        end
        rxd = stopb;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    task automatic pop_one();
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    task automatic clear_pulse();
        clr_status = 1'b1;
        @(negedge clk);
        clr_status = 1'b0;
    endtask

    // {size, par_en, par_odd, flip, stop, data, exp_data, exp_perr, exp_ferr}
    localparam int NV = 8;
    localparam logic [26:0] VEC [NV] = '{
        {3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h0A5, 9'h0A5, 1'b0, 1'b0},
        {3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 9'h1C3, 9'h1C3, 1'b0, 1'b0},
        {3'd5, 1'b1, 1'b1, 1'b0, 1'b1, 9'h1FF, 9'h01F, 1'b0, 1'b0},
        {3'd6, 1'b1, 1'b0, 1'b1, 1'b1, 9'h02D, 9'h02D, 1'b1, 1'b0},
        {3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 9'h055, 9'h055, 1'b0, 1'b1},
        {3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 9'h13C, 9'h03C, 1'b0, 1'b0},
        {3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 9'h000, 9'h000, 1'b1, 1'b0},
        {3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h100, 9'h100, 1'b0, 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int s0, w0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rd_valid", rd_valid, 0);
        check("R1 flags", {err_frame, err_parity, err_overrun}, 0);
        check("R1 start_pulse", start_pulse, 0);
        check("R1 wake", wake, 0);
        rst = 1'b0;
        rx_en = 1'b1;
        repeat (20) @(negedge clk);

        // Table walk: R3 R4 R5 R10
        for (int v = 0; v < NV; v++) begin
            logic [26:0] e;
            e = VEC[v];
            char_size = e[26:24];
            par_en    = e[23];
            par_odd   = e[22];
            s0 = n_start;
            send(e[19:11], e[26:24], e[23], e[22], e[21], e[20]);
            check("R6 valid after frame", rd_valid, 1);
            check("R3 data", rd_data, e[10:2]);
            check("R4 parity flag", err_parity, e[1]);
            check("R5 frame flag", err_frame, e[0]);
            check("R10 one start per frame", n_start - s0, 1);
            pop_one();
            clear_pulse();
            check("R9 clear", {err_frame, err_parity, err_overrun}, 0);
        end
        char_size = 3'd0; par_en = 1'b0; par_odd = 1'b0;

        // R2: short low glitch ignored
        s0 = n_start;
        @(negedge clk); rxd = 1'b0;
        repeat (5) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        check("R2 no start on glitch", n_start - s0, 0);
        check("R2 no char on glitch", rd_valid, 0);

        // R6 R7: three frames without reading
        send(9'h011, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        send(9'h022, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R7 no overrun at two", err_overrun, 0);
        send(9'h033, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R7 overrun set", err_overrun, 1);
        check("R6 head first", rd_data, 9'h011);
        pop_one();
        check("R6 second", rd_data, 9'h022);
        check("R7 second kept", rd_valid, 1);
        pop_one();
        check("R7 third dropped", rd_valid, 0);

        // R8: disable flushes and clears
        send(9'h044, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R8 pre valid", rd_valid, 1);
        check("R8 pre overrun", err_overrun, 1);
        rx_en = 1'b0;
        @(negedge clk);
        check("R8 buffer flushed", rd_valid, 0);
        check("R8 flags cleared", {err_frame, err_parity, err_overrun}, 0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // R9: clear in the same cycle as a frame-error set (8 data bits, stop index 9)
        fork
            send(9'h0F0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
            begin
                repeat (154) @(negedge clk);
                clr_status = 1'b1;
                @(negedge clk);
                clr_status = 1'b0;
            end
        join
        check("R9 set wins over clear", err_frame, 1);
        check("R5 char kept with bad stop", rd_data, 9'h0F0);
        clear_pulse();
        check("R9 clear alone", err_frame, 0);
        pop_one();

        // R11: wake gating
        sof_en = 1'b0; ie_start = 1'b1; ie_done = 1'b1;
        w0 = n_wake;
        send(9'h05A, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1); pop_one();
        check("R11 detect off", n_wake - w0, 0);
        sof_en = 1'b1; ie_start = 1'b1; ie_done = 1'b0;
        w0 = n_wake;
        send(9'h05A, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1); pop_one();
        check("R11 start only", n_wake - w0, 1);
        ie_start = 1'b0; ie_done = 1'b1;
        w0 = n_wake;
        send(9'h05A, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1); pop_one();
        check("R11 done only", n_wake - w0, 1);
        ie_start = 1'b1; ie_done = 1'b1;
        w0 = n_wake;
        send(9'h05A, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1); pop_one();
        check("R11 both selects", n_wake - w0, 2);
        ie_start = 1'b0; ie_done = 1'b0;
        w0 = n_wake;
        send(9'h05A, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1); pop_one();
        check("R11 no select", n_wake - w0, 0);

        report();
    end

endmodule